// File: doc/BRIEF.md
# Peripheral Clock-Enable Strobe Generator

This block derives one-cycle enable strobes for the peripherals of a small system-on-chip from a single fast system clock. The strobes are not clocks. A peripheral flop that sees its strobe high on a rising system-clock edge acts as if its own slower clock had ticked. A source-select input picks the origin of the core rate. That origin is either a PLL-derived core frequency or a fixed 13 MHz external oscillator. Every downstream ratio (bus, UART, SPI reference, PWM, timer reference) depends on that choice.

Frequencies are elaboration parameters. Each ratio is the nearest integer divide of the system clock, worked out when the block is elaborated. The core strobe feeds a cascade of counters, and each counter advances only on the strobe of the stage above it. Two plain select inputs add a last prescale stage: a 2-bit code on the SPI branch and one bit on the timer branch. A free-running low-rate tick output does not depend on the source select.

A change of the source select restarts every divider except the tick. A change of a prescale select restarts only its own branch. Each output's first strobe then comes one full period of the new setting later. The block has no data path, so all pins are plain level controls and one-cycle strobes.

Top module: `periph_strobe_gen`

## Requirements
- R1: While `rst_n` is low no strobe is issued and all dividers hold zero. After release, an output of period P sys cycles first pulses in the P-th cycle, counting the release cycle as the first.
- R2: Each strobe is high for one sys cycle per period. The core period is round(SYS_HZ/PLL_HZ) sys cycles when `src_ext`=0 and round(SYS_HZ/EXT_HZ) when `src_ext`=1, never below 1.
- R3: With `src_ext`=0, `ce_spi_ref` fires every 576 core strobes, `ce_pwm` every 768 and `ce_tmr_ref` every 144.
- R4: With `src_ext`=0, `ce_bus` fires every 2 core strobes if PLL_HZ is above 36 864 000. Otherwise it fires every round(SYS_HZ/18 432 000) sys cycles.
- R5: With `src_ext`=1, `ce_bus` equals `ce_core`, `ce_spi_ref` fires every 96 core strobes and `ce_pwm` every 128.
- R6: With `src_ext`=1, `ce_tmr_ref` fires every 26 core strobes when `tmr_alt`=1 and every 24 when it is 0. With `src_ext`=0, `tmr_alt` does not change the timer reference period.
- R7: `ce_spi` divides `ce_spi_ref` by 32, 8, 2 or 1 for `spi_code` 0, 1, 2 or 3.
- R8: `ce_tmr` divides `ce_tmr_ref` by 256 when `tmr_fast`=0 and by 1 when `tmr_fast`=1.
- R9: `ce_uart` fires every 10 `ce_bus` strobes and only together with one.
- R10: `ce_tick` fires every round(SYS_HZ/TICK_HZ) sys cycles, whatever the selects.
- R11: In a cycle where `src_ext` differs from its value at the previous edge, no strobe other than `ce_tick` is issued, and all other dividers restart. An output of period P then first pulses P cycles after that change cycle.
- R12: A change of `spi_code` restarts only the SPI reference and SPI dividers. A change of `tmr_alt` or `tmr_fast` restarts only the timer reference and timer dividers. All other outputs keep their phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | fast system clock |
| rst_n | input | 1 | active-low synchronous reset |
| src_ext | input | 1 | 1 selects the 13 MHz external source, 0 the PLL source |
| spi_code | input | 2 | SPI prescale code (0:/32, 1:/8, 2:/2, 3:/1) |
| tmr_alt | input | 1 | external-source timer reference uses /26 when 1, /24 when 0 |
| tmr_fast | input | 1 | timer prescale /1 when 1, /256 when 0 |
| ce_core | output | 1 | core-rate strobe |
| ce_bus | output | 1 | bus-rate strobe |
| ce_uart | output | 1 | UART-rate strobe |
| ce_spi_ref | output | 1 | SPI reference strobe |
| ce_spi | output | 1 | prescaled SPI strobe |
| ce_pwm | output | 1 | PWM strobe |
| ce_tmr_ref | output | 1 | timer reference strobe |
| ce_tmr | output | 1 | prescaled timer strobe |
| ce_tick | output | 1 | low-rate periodic tick |

## Verification
The assertions assume that the select inputs change only between edges and stay stable through each sampling edge. They also assume that the parameters give every divider a limit of at least 1. The counter-range property relies on each limit changing only in the cycle that clears its counter. That holds because every limit is decoded from the same inputs whose change raises the clear. The stimulus changes selects only at the falling edge and only one group at a time. Exact first-strobe positions after a prescale change are checked only where the core divider is 1, so the untouched core stage cannot shift the phase.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int RATIO_W = 10;
  localparam int SPI_W   = 6;
  localparam int TMR_W   = 9;

  localparam int THRESH_HZ   = 36_864_000;
  localparam int BUS_FIX_HZ  = 18_432_000;

  localparam int PLL_SPI_DIV  = 576;
  localparam int PLL_PWM_DIV  = 768;
  localparam int PLL_TREF_DIV = 144;
  localparam int PLL_BUS_DIV  = 2;
  localparam int EXT_SPI_DIV  = 96;
  localparam int EXT_PWM_DIV  = 128;
  localparam int EXT_TREF_STD = 24;
  localparam int EXT_TREF_ALT = 26;
  localparam int UART_DIV     = 10;
  localparam int TMR_SLOW_DIV = 256;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // nearest integer divide, never below 1
  function automatic int round_div(input int num, input int den);
    return imax(1, (num + den / 2) / den);
  endfunction

  function automatic logic [SPI_W-1:0] spi_prescale(input logic [1:0] code);
    case (code)
      2'd0:    return SPI_W'(32);
      2'd1:    return SPI_W'(8);
      2'd2:    return SPI_W'(2);
      default: return SPI_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/psg_div.sv
module psg_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick_in,
  input  logic [W-1:0] limit,
  output logic         strobe
);
  logic [W-1:0] cnt;
  logic         at_end;

  assign at_end = (cnt == limit - W'(1));
  assign strobe = rst_n && !clr && tick_in && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt <= '0;
    else if (tick_in)
      cnt <= at_end ? '0 : cnt + W'(1);
  end

  // R2: counter stays inside the period selected by its limit
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt < limit));

  // R11: a clear restarts the count from zero
  p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/psg_presel.sv
module psg_presel
  import psg_pkg::*;
(
  input  logic               src_ext,
  input  logic [1:0]         spi_code,
  input  logic               tmr_alt,
  input  logic               tmr_fast,
  output logic [RATIO_W-1:0] spi_ref_lim,
  output logic [RATIO_W-1:0] pwm_lim,
  output logic [RATIO_W-1:0] tref_lim,
  output logic [SPI_W-1:0]   spi_lim,
  output logic [TMR_W-1:0]   tmr_lim
);
  always_comb begin
    if (src_ext) begin
      spi_ref_lim = RATIO_W'(EXT_SPI_DIV);
      pwm_lim     = RATIO_W'(EXT_PWM_DIV);
      tref_lim    = tmr_alt ? RATIO_W'(EXT_TREF_ALT) : RATIO_W'(EXT_TREF_STD);
    end else begin
      spi_ref_lim = RATIO_W'(PLL_SPI_DIV);
      pwm_lim     = RATIO_W'(PLL_PWM_DIV);
      tref_lim    = RATIO_W'(PLL_TREF_DIV);
    end
    spi_lim = spi_prescale(spi_code);
    tmr_lim = tmr_fast ? TMR_W'(1) : TMR_W'(TMR_SLOW_DIV);
  end
endmodule

// File: rtl/periph_strobe_gen.sv
module periph_strobe_gen
  import psg_pkg::*;
#(
  parameter int SYS_HZ  = 147_456_000,
  parameter int PLL_HZ  = 73_728_000,
  parameter int EXT_HZ  = 13_000_000,
  parameter int TICK_HZ = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_ext,
  input  logic [1:0] spi_code,
  input  logic       tmr_alt,
  input  logic       tmr_fast,
  output logic       ce_core,
  output logic       ce_bus,
  output logic       ce_uart,
  output logic       ce_spi_ref,
  output logic       ce_spi,
  output logic       ce_pwm,
  output logic       ce_tmr_ref,
  output logic       ce_tmr,
  output logic       ce_tick
);
  localparam int CORE_PLL    = round_div(SYS_HZ, PLL_HZ);
  localparam int CORE_EXT    = round_div(SYS_HZ, EXT_HZ);
  localparam int CORE_W      = $clog2(imax(CORE_PLL, CORE_EXT) + 1);
  localparam bit BUS_FAST    = (PLL_HZ > THRESH_HZ);
  localparam int BUS_FIX_DIV = round_div(SYS_HZ, BUS_FIX_HZ);
  localparam int BUS_W       = $clog2(imax(PLL_BUS_DIV, BUS_FIX_DIV) + 1);
  localparam int UART_W      = $clog2(UART_DIV + 1);
  localparam int TICK_DIV    = round_div(SYS_HZ, TICK_HZ);
  localparam int TICK_W      = $clog2(TICK_DIV + 1);

  // shadow copies of the selects, tracked even in reset
  logic       ext_q, alt_q, fast_q;
  logic [1:0] spi_q;
  always_ff @(posedge clk) begin
    ext_q  <= src_ext;
    spi_q  <= spi_code;
    alt_q  <= tmr_alt;
    fast_q <= tmr_fast;
  end

  logic chg_mode, clr_spi, clr_tmr;
  assign chg_mode = (src_ext != ext_q);
  assign clr_spi  = chg_mode || (spi_code != spi_q);
  assign clr_tmr  = chg_mode || (tmr_alt != alt_q) || (tmr_fast != fast_q);

  logic [RATIO_W-1:0] spi_ref_lim, pwm_lim, tref_lim;
  logic [SPI_W-1:0]   spi_lim;
  logic [TMR_W-1:0]   tmr_lim;

  psg_presel u_presel (
    .src_ext    (src_ext),
    .spi_code   (spi_code),
    .tmr_alt    (tmr_alt),
    .tmr_fast   (tmr_fast),
    .spi_ref_lim(spi_ref_lim),
    .pwm_lim    (pwm_lim),
    .tref_lim   (tref_lim),
    .spi_lim    (spi_lim),
    .tmr_lim    (tmr_lim)
  );

  logic [CORE_W-1:0] core_lim;
  logic [BUS_W-1:0]  bus_lim;
  logic              bus_src;

  assign core_lim = src_ext ? CORE_W'(CORE_EXT) : CORE_W'(CORE_PLL);

  generate
    if (BUS_FAST) begin : g_bus_from_core
      assign bus_src = ce_core;
      assign bus_lim = src_ext ? BUS_W'(1) : BUS_W'(PLL_BUS_DIV);
    end else begin : g_bus_fixed
      assign bus_src = src_ext ? ce_core : 1'b1;
      assign bus_lim = src_ext ? BUS_W'(1) : BUS_W'(BUS_FIX_DIV);
    end
  endgenerate

  psg_div #(.W(CORE_W)) u_core (.clk(clk), .rst_n(rst_n), .clr(chg_mode),
    .tick_in(1'b1), .limit(core_lim), .strobe(ce_core));

  psg_div #(.W(BUS_W)) u_bus (.clk(clk), .rst_n(rst_n), .clr(chg_mode),
    .tick_in(bus_src), .limit(bus_lim), .strobe(ce_bus));

  psg_div #(.W(UART_W)) u_uart (.clk(clk), .rst_n(rst_n), .clr(chg_mode),
    .tick_in(ce_bus), .limit(UART_W'(UART_DIV)), .strobe(ce_uart));

  psg_div #(.W(RATIO_W)) u_spi_ref (.clk(clk), .rst_n(rst_n), .clr(clr_spi),
    .tick_in(ce_core), .limit(spi_ref_lim), .strobe(ce_spi_ref));

  psg_div #(.W(SPI_W)) u_spi (.clk(clk), .rst_n(rst_n), .clr(clr_spi),
    .tick_in(ce_spi_ref), .limit(spi_lim), .strobe(ce_spi));

  psg_div #(.W(RATIO_W)) u_pwm (.clk(clk), .rst_n(rst_n), .clr(chg_mode),
    .tick_in(ce_core), .limit(pwm_lim), .strobe(ce_pwm));

  psg_div #(.W(RATIO_W)) u_tref (.clk(clk), .rst_n(rst_n), .clr(clr_tmr),
    .tick_in(ce_core), .limit(tref_lim), .strobe(ce_tmr_ref));

  psg_div #(.W(TMR_W)) u_tmr (.clk(clk), .rst_n(rst_n), .clr(clr_tmr),
    .tick_in(ce_tmr_ref), .limit(tmr_lim), .strobe(ce_tmr));

  psg_div #(.W(TICK_W)) u_tick (.clk(clk), .rst_n(rst_n), .clr(1'b0),
    .tick_in(1'b1), .limit(TICK_W'(TICK_DIV)), .strobe(ce_tick));

  // R1: silent while reset is held
  p_silent_reset_r1: assert property (@(posedge clk)
    !rst_n |-> !(ce_core || ce_bus || ce_uart || ce_spi_ref || ce_spi ||
                 ce_pwm || ce_tmr_ref || ce_tmr || ce_tick));

  // R9: UART strobe only coincides with a bus strobe
  p_uart_on_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_uart |-> ce_bus);

  // R7: prescaled SPI strobe only on an SPI reference strobe
  p_spi_on_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ce_spi |-> ce_spi_ref);

  // R8: prescaled timer strobe only on a timer reference strobe
  p_tmr_on_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_tmr |-> ce_tmr_ref);

  // R5: with the external source the bus follows the core exactly
  p_bus_is_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ext && !chg_mode) |-> (ce_bus == ce_core));

  // R11: source change cycle issues no mode-dependent strobe
  p_mode_change_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ext != $past(src_ext)) |-> !(ce_core || ce_bus || ce_uart ||
      ce_spi_ref || ce_spi || ce_pwm || ce_tmr_ref || ce_tmr));
endmodule

// File: tb/tb_periph_strobe_gen.sv
module tb_periph_strobe_gen;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       src_ext = 1'b0;
  logic [1:0] spi_code = 2'd3;
  logic       tmr_alt = 1'b0;
  logic       tmr_fast = 1'b1;

  logic [8:0] o_a, o_b;

  periph_strobe_gen #(.SYS_HZ(73_728_000), .PLL_HZ(73_728_000),
    .EXT_HZ(13_000_000), .TICK_HZ(73_728)) dut (
    .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .spi_code(spi_code),
    .tmr_alt(tmr_alt), .tmr_fast(tmr_fast),
    .ce_core(o_a[0]), .ce_bus(o_a[1]), .ce_uart(o_a[2]), .ce_spi_ref(o_a[3]),
    .ce_spi(o_a[4]), .ce_pwm(o_a[5]), .ce_tmr_ref(o_a[6]), .ce_tmr(o_a[7]),
    .ce_tick(o_a[8]));

  periph_strobe_gen #(.SYS_HZ(73_728_000), .PLL_HZ(36_864_000),
    .EXT_HZ(13_000_000), .TICK_HZ(73_728)) dut_slow (
    .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .spi_code(spi_code),
    .tmr_alt(tmr_alt), .tmr_fast(tmr_fast),
    .ce_core(o_b[0]), .ce_bus(o_b[1]), .ce_uart(o_b[2]), .ce_spi_ref(o_b[3]),
    .ce_spi(o_b[4]), .ce_pwm(o_b[5]), .ce_tmr_ref(o_b[6]), .ce_tmr(o_b[7]),
    .ce_tick(o_b[8]));

  int checks = 0;
  int errors = 0;

  // {req[47:44], pad[43:41], ext[40], spi[39:38], alt[37], fast[36], idx[35:32], first[31:0]}
  // idx: 0 core,1 bus,2 uart,3 spi_ref,4 spi,5 pwm,6 tmr_ref,7 tmr,8 tick
  // first = P-1 windows after reset release
  localparam logic [47:0] VEC [19] = '{
    {4'd2,  3'd0, 1'b0, 2'd3, 1'b0, 1'b1, 4'd0, 32'd0},    // R2 PLL core /1
    {4'd4,  3'd0, 1'b0, 2'd3, 1'b0, 1'b1, 4'd1, 32'd1},    // R4 PLL bus /2
    {4'd9,  3'd0, 1'b0, 2'd3, 1'b0, 1'b1, 4'd2, 32'd19},   // R9 uart 20
    {4'd3,  3'd0, 1'b0, 2'd3, 1'b0, 1'b1, 4'd3, 32'd575},  // R3 spi_ref
    {4'd3,  3'd0, 1'b0, 2'd3, 1'b0, 1'b1, 4'd5, 32'd767},  // R3 pwm
    {4'd3,  3'd0, 1'b0, 2'd3, 1'b0, 1'b1, 4'd6, 32'd143},  // R3 tref
    {4'd6,  3'd0, 1'b0, 2'd3, 1'b1, 1'b1, 4'd6, 32'd143},  // R6 alt ignored in PLL
    {4'd7,  3'd0, 1'b0, 2'd3, 1'b0, 1'b1, 4'd4, 32'd575},  // R7 code3 /1
    {4'd7,  3'd0, 1'b0, 2'd2, 1'b0, 1'b1, 4'd4, 32'd1151}, // R7 code2 /2
    {4'd8,  3'd0, 1'b0, 2'd3, 1'b0, 1'b1, 4'd7, 32'd143},  // R8 fast /1
    {4'd2,  3'd0, 1'b1, 2'd3, 1'b0, 1'b1, 4'd0, 32'd5},    // R2 ext core /6
    {4'd5,  3'd0, 1'b1, 2'd3, 1'b0, 1'b1, 4'd1, 32'd5},    // R5 ext bus
    {4'd9,  3'd0, 1'b1, 2'd3, 1'b0, 1'b1, 4'd2, 32'd59},   // R9 ext uart
    {4'd5,  3'd0, 1'b1, 2'd3, 1'b0, 1'b1, 4'd3, 32'd575},  // R5 ext spi_ref
    {4'd5,  3'd0, 1'b1, 2'd3, 1'b0, 1'b1, 4'd5, 32'd767},  // R5 ext pwm
    {4'd6,  3'd0, 1'b1, 2'd3, 1'b0, 1'b1, 4'd6, 32'd143},  // R6 ext /24
    {4'd6,  3'd0, 1'b1, 2'd3, 1'b1, 1'b1, 4'd6, 32'd155},  // R6 ext /26
    {4'd7,  3'd0, 1'b1, 2'd1, 1'b0, 1'b1, 4'd4, 32'd4607}, // R7 ext code1 /8
    {4'd10, 3'd0, 1'b0, 2'd3, 1'b0, 1'b1, 4'd8, 32'd999}   // R10 tick
  };

  function automatic logic get_out(input int idx, input bit slow);
    return slow ? o_b[idx] : o_a[idx];
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic apply(input logic ext, input logic [1:0] sc,
                       input logic alt, input logic fast);
    @(negedge clk);
    rst_n = 1'b0;
    src_ext = ext; spi_code = sc; tmr_alt = alt; tmr_fast = fast;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic wait_strobe(input int idx, input bit slow, input int maxc,
                             output int pos);
    pos = 0;
    while (!get_out(idx, slow) && pos <= maxc) begin
      step();
      pos++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pos, pos2, busy;

    // R1: nothing while reset is held
    busy = 0;
    for (int k = 0; k < 8; k++) begin
      step();
      if (o_a != 9'd0 || o_b != 9'd0) busy++;
    end
    check("R1 strobes during reset", busy, 0);

    // vector table, each from a fresh reset release
    for (int v = 0; v < 19; v++) begin
      apply(VEC[v][40], VEC[v][39:38], VEC[v][37], VEC[v][36]);
      wait_strobe(int'(VEC[v][35:32]), 1'b0, int'(VEC[v][31:0]) + 10, pos);
      check($sformatf("R%0d vector %0d first strobe", VEC[v][47:44], v),
            pos, int'(VEC[v][31:0]));
    end

    // R4 / R2: slow PLL instance, core /2 and fixed bus /4
    apply(1'b0, 2'd3, 1'b0, 1'b1);
    wait_strobe(0, 1'b1, 20, pos);
    check("R2 slow core first", pos, 1);
    apply(1'b0, 2'd3, 1'b0, 1'b1);
    wait_strobe(1, 1'b1, 20, pos);
    check("R4 slow fixed bus first", pos, 3);

    // R11: source change restarts, first pwm a full period later
    apply(1'b0, 2'd3, 1'b0, 1'b1);
    repeat (50) step();
    @(negedge clk);
    src_ext = 1'b1;
    #1;
    wait_strobe(5, 1'b0, 900, pos);
    check("R11 pwm after source change", pos, 768);

    // R2: uart period in external mode, single-cycle pulses
    wait_strobe(2, 1'b0, 200, pos);
    step();
    check("R2 uart pulse width", int'(o_a[2]), 0);
    wait_strobe(2, 1'b0, 200, pos2);
    check("R2 ext uart period", pos2 + 1, 60);

    // R12 / R7: spi code change restarts SPI chain only
    apply(1'b0, 2'd3, 1'b0, 1'b1);
    repeat (100) step();
    @(negedge clk);
    spi_code = 2'd0;
    #1;
    wait_strobe(5, 1'b0, 900, pos);
    check("R12 pwm keeps phase across spi change", pos + 101, 767);

    apply(1'b0, 2'd3, 1'b0, 1'b1);
    repeat (30) step();
    @(negedge clk);
    spi_code = 2'd0;
    #1;
    wait_strobe(4, 1'b0, 19000, pos);
    check("R12 R7 spi /32 after code change", pos, 18432);

    // R12 / R8: timer prescale change to /256
    apply(1'b0, 2'd3, 1'b0, 1'b1);
    repeat (30) step();
    @(negedge clk);
    tmr_fast = 1'b0;
    #1;
    wait_strobe(7, 1'b0, 37000, pos);
    check("R12 R8 timer /256 after change", pos, 36864);

    // R12 / R6: alt toggle in PLL mode restarts timer ref, same period
    apply(1'b0, 2'd3, 1'b0, 1'b1);
    repeat (30) step();
    @(negedge clk);
    tmr_alt = 1'b1;
    #1;
    wait_strobe(6, 1'b0, 300, pos);
    check("R12 R6 tref restart in PLL mode", pos, 144);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule